// File: doc/BRIEF.md
# Circular Passing-Window Phase Selector

After a receive-clock tuning sweep, each of the sixteen sampling phases is known to pass or fail. This block takes that result as a 16-bit mask, with bit k standing for phase k. It groups the passing phases into runs of adjacent phase numbers and finds the longest run. Phase 15 and phase 0 count as neighbours, so a run that ends at 15 and a run that starts at 0 join into one window. The block then returns a phase three quarters of the way into that window. This gives a sampling point that leans toward the late edge of the eye.

A search starts when `start_i` is pulsed with the mask present. The block latches the mask and walks the phases one per cycle. It then pulses either `valid_o` or `err_o` for one cycle. The selected phase stays on `phase_o` until the next search completes. Any start request made while a search is running is dropped.

Top module: `phase_window_sel`

## Requirements
- R1: After reset, `phase_o` is 0 and both `valid_o` and `err_o` are 0.
- R2: `start_i` is sampled on a rising edge. The result flag rises at the 16th rising edge after that edge, and neither flag is high before then.
- R3: Let a chosen window have length L and first phase S. The offset is k = floor(3L/4) - 1, or 0 when floor(3L/4) is 0. The result is phase (S + k) mod 16.
- R4: When runs differ in length, the longest run is the one chosen.
- R5: When several runs share the greatest length, the run whose first phase is lowest wins. A merged window starts at its phase-15 side, so it ranks after every run that does not wrap.
- R6: Suppose phase 0 and phase 15 both pass but not every phase passes. Then the run ending at 15 and the run starting at 0 form one window. It starts at the first phase of the run that ends at 15, and its length is the sum of the two runs.
- R7: A mask with all bits set is a single window starting at 0 with length 16, and it selects phase 11.
- R8: A mask of all zeros raises `err_o` for one cycle with `valid_o` low, and sets `phase_o` to 0.
- R9: `valid_o` and `err_o` are one-cycle pulses and are never high together. `phase_o` changes only in a cycle where one of them is high.
- R10: A `start_i` pulse that arrives while a search is in progress has no effect. The running search completes on its own schedule with its own mask, and no extra result follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search on the mask present this cycle |
| mask_i | input | 16 | Pass (1) / fail (0) per sampling phase, bit k = phase k |
| phase_o | output | 4 | Selected sampling phase, held between searches |
| valid_o | output | 1 | One-cycle pulse: a phase was selected |
| err_o | output | 1 | One-cycle pulse: no phase passed |

## Verification
The assertions assume that the mask is captured only when the block is idle. They also assume that the result in each completion cycle depends only on that captured mask. So the error pulse is tied to an all-zero captured mask, and the valid pulse is tied to a non-zero one. Between completions, the assertions hold the output phase steady and let `start_i` toggle at any time.

The stimulus presents each mask with a single-cycle start. It then waits out the full sweep before it starts the next search. The one exception is a directed case that fires a second start in the middle of a sweep, to show that the second start is dropped.

// File: rtl/phase_sel_pkg.sv
package phase_sel_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/ring_lead_count.sv
// Counts passing phases from phase 0 upward and flags a wrap-around run.
module ring_lead_count #(
  parameter int N  = 16,
  parameter int LW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask_i,
  output logic [LW-1:0] lead_o,
  output logic          wrap_o
);
  logic run_on;

  always_comb begin
    lead_o = '0;
    run_on = 1'b1;
    for (int k = 0; k < N; k++) begin
      if (run_on && mask_i[k]) lead_o = lead_o + LW'(1);
      else                     run_on = 1'b0;
    end
  end

  assign wrap_o = mask_i[0] & mask_i[N-1] & ~(&mask_i);
endmodule

// File: rtl/window_pick.sv
// Offset three quarters into a window, taken modulo the phase count.
module window_pick #(
  parameter int N  = 16,
  parameter int PW = $clog2(N),
  parameter int LW = $clog2(N + 1)
) (
  input  logic [PW-1:0] start_i,
  input  logic [LW-1:0] len_i,
  output logic [PW-1:0] phase_o
);
  localparam int SW = LW + 2;

  logic [SW-1:0] tri_len, quarter, offset, sum, wrapped;

  always_comb begin
    tri_len = SW'(len_i) + SW'({len_i, 1'b0});
    quarter = tri_len >> 2;
    offset  = (quarter == '0) ? '0 : quarter - SW'(1);
    sum     = SW'(start_i) + offset;
    wrapped = (sum >= SW'(N)) ? sum - SW'(N) : sum;
    phase_o = wrapped[PW-1:0];
  end
endmodule

// File: rtl/run_scanner.sv
// Walks one phase per cycle, tracking the current run and the best run so far.
module run_scanner
  import phase_sel_pkg::*;
#(
  parameter int N  = 16,
  parameter int PW = $clog2(N),
  parameter int LW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  mask_i,
  input  logic [LW-1:0] lead_i,
  input  logic          wrap_i,
  output logic [N-1:0]  mask_q_o,
  output logic          done_o,
  output logic [PW-1:0] best_start_o,
  output logic [LW-1:0] best_len_o
);
  scan_state_e   state_q;
  logic [PW-1:0] idx_q, cur_start_q, best_start_q, start_n;
  logic [LW-1:0] cur_len_q, best_len_q, len_n, cand_len;
  logic [N-1:0]  mask_q;
  logic          is_last, bit_now, bit_next, run_end, skip_lead, take;

  always_comb begin
    is_last   = (idx_q == PW'(N - 1));
    bit_now   = mask_q[idx_q];
    bit_next  = is_last ? 1'b0 : mask_q[PW'(idx_q + PW'(1))];
    len_n     = bit_now ? cur_len_q + LW'(1) : '0;
    start_n   = (bit_now && cur_len_q == '0) ? idx_q : cur_start_q;
    run_end   = bit_now && (is_last || !bit_next);
    // leading run is folded into the wrapping one at the last phase
    skip_lead = wrap_i && (start_n == '0);
    cand_len  = len_n + ((is_last && wrap_i) ? lead_i : '0);
    take      = (state_q == ST_SCAN) && run_end && !skip_lead && (cand_len > best_len_q);
    best_start_o = take ? start_n  : best_start_q;
    best_len_o   = take ? cand_len : best_len_q;
    done_o       = (state_q == ST_SCAN) && is_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      mask_q       <= '0;
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q      <= ST_SCAN;
        mask_q       <= mask_i;
        idx_q        <= '0;
        cur_start_q  <= '0;
        cur_len_q    <= '0;
        best_start_q <= '0;
        best_len_q   <= '0;
      end
    end else begin
      cur_start_q  <= start_n;
      cur_len_q    <= len_n;
      best_start_q <= best_start_o;
      best_len_q   <= best_len_o;
      idx_q        <= idx_q + PW'(1);
      if (is_last) state_q <= ST_IDLE;
    end
  end

  assign mask_q_o = mask_q;

  assert_len_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    best_len_q <= LW'(N));
  assert_mask_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && !is_last) |=> $stable(mask_q));
endmodule

// File: rtl/phase_window_sel.sv
module phase_window_sel #(
  parameter int NUM_PHASES = 16,
  localparam int PW = $clog2(NUM_PHASES),
  localparam int LW = $clog2(NUM_PHASES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NUM_PHASES-1:0] mask_i,
  output logic [PW-1:0]         phase_o,
  output logic                  valid_o,
  output logic                  err_o
);
  logic [NUM_PHASES-1:0] mask_q;
  logic [LW-1:0]         lead, best_len;
  logic [PW-1:0]         best_start, pick;
  logic                  wrap, done;

  ring_lead_count #(.N(NUM_PHASES), .LW(LW)) i_lead (
    .mask_i (mask_q),
    .lead_o (lead),
    .wrap_o (wrap)
  );

  run_scanner #(.N(NUM_PHASES), .PW(PW), .LW(LW)) i_scan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mask_i       (mask_i),
    .lead_i       (lead),
    .wrap_i       (wrap),
    .mask_q_o     (mask_q),
    .done_o       (done),
    .best_start_o (best_start),
    .best_len_o   (best_len)
  );

  window_pick #(.N(NUM_PHASES), .PW(PW), .LW(LW)) i_pick (
    .start_i (best_start),
    .len_i   (best_len),
    .phase_o (pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (done) begin
        if (best_len != '0) begin
          valid_o <= 1'b1;
          phase_o <= pick;
        end else begin
          err_o   <= 1'b1;
          phase_o <= '0;
        end
      end
    end
  end

  assert_flags_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));
  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  assert_phase_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o || err_o) |-> $stable(phase_o));
  assert_err_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (mask_q == '0));
  assert_valid_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mask_q != '0));
endmodule

// File: tb/test_phase_window_sel.sv
module test_phase_window_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic [3:0]  phase_o;
  logic        valid_o, err_o;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk_i = ~clk_i;

  phase_window_sel i_phase_window_sel (
    .clk_i, .rst_ni, .start_i, .mask_i, .phase_o, .valid_o, .err_o
  );

  // {mask, expected phase, expected error}
  localparam logic [20:0] VEC [16] = '{
    {16'hFFFF, 4'd11, 1'b0},  // R7
    {16'h0000, 4'd0,  1'b1},  // R8
    {16'h0001, 4'd0,  1'b0},  // R3
    {16'h8000, 4'd15, 1'b0},  // R3
    {16'h00F0, 4'd6,  1'b0},  // R3
    {16'hC003, 4'd0,  1'b0},  // R6
    {16'h81F3, 4'd6,  1'b0},  // R4
    {16'h0F0F, 4'd2,  1'b0},  // R5
    {16'hC1E3, 4'd7,  1'b0},  // R5 tie with wrap
    {16'hF807, 4'd0,  1'b0},  // R6
    {16'h7FFF, 4'd10, 1'b0},  // R3
    {16'hFFFE, 4'd11, 1'b0},  // R3
    {16'hFF7F, 4'd2,  1'b0},  // R6
    {16'h5555, 4'd0,  1'b0},  // R5
    {16'h0006, 4'd1,  1'b0},  // R3
    {16'h0038, 4'd4,  1'b0}   // R3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent model: runs by ascending start, circular length, strict compare.
  function automatic logic [4:0] model(input logic [15:0] m);
    int best_s = 0, best_l = 0, off;
    if (m == 16'h0000) return 5'h10;
    if (m == 16'hFFFF) begin best_s = 0; best_l = 16; end
    else begin
      for (int s = 0; s < 16; s++) begin
        if (m[s] && !m[(s + 15) % 16]) begin
          int l = 0;
          while (m[(s + l) % 16]) l++;
          if (l > best_l) begin best_l = l; best_s = s; end
        end
      end
    end
    off = (best_l * 3) / 4;
    if (off > 0) off--;
    return {1'b0, 4'((best_s + off) % 16)};
  endfunction

  task automatic run(input logic [15:0] m, input logic [3:0] ep, input logic ee, input string req);
    @(negedge clk_i);
    start_i = 1'b1;
    mask_i  = m;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    mask_i  = ~m;
    repeat (15) @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 early flags", {6'd0, valid_o, err_o}, 8'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk({req, " valid"}, {7'd0, valid_o}, {7'd0, ~ee});
    chk({req, " err"},   {7'd0, err_o},   {7'd0, ee});
    chk({req, " phase"}, {4'd0, phase_o}, {4'd0, ep});
    @(negedge clk_i);
    chk("R9 pulse drop", {6'd0, valid_o, err_o}, 8'd0);
    chk("R9 phase held", {4'd0, phase_o}, {4'd0, ep});
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    logic        seen;
    repeat (3) @(negedge clk_i);
    chk("R1 reset", {3'd0, phase_o, valid_o}, 8'd0);
    chk("R1 reset err", {7'd0, err_o}, 8'd0);
    rst_ni = 1'b1;

    foreach (VEC[i]) run(VEC[i][20:5], VEC[i][4:1], VEC[i][0], "R3-table");
    chk("R7 all pass", {3'd0, model(16'hFFFF)}, 8'd11);

    lf = 16'hACE1;
    for (int n = 0; n < 24; n++) begin
      logic [4:0] e;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      e  = model(lf);
      run(lf, e[3:0], e[4], "R4 sweep");
    end

    // R10: second start mid-search is dropped
    @(negedge clk_i);
    start_i = 1'b1;
    mask_i  = 16'h00F0;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    start_i = 1'b1;
    mask_i  = 16'hFFFF;
    @(negedge clk_i);
    start_i = 1'b0;
    mask_i  = '0;
    repeat (10) @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R10 valid on time", {7'd0, valid_o}, 8'd1);
    chk("R10 first mask result", {4'd0, phase_o}, 8'd6);
    seen = 1'b0;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk_i);
      if (valid_o || err_o) seen = 1'b1;
    end
    chk("R10 no extra result", {7'd0, seen}, 8'd0);
    chk("R10 phase held", {4'd0, phase_o}, 8'd6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule